// File: doc/BRIEF.md
# Clock-Mode Selectable Dual-Clock FIFO

This block is a parameterised first-in first-out queue that moves command or data words from one clock domain to another, for example between a bus-side port and a memory-core engine. A word is pushed on the write side when `wr_valid_i` is high and `wr_full_o` is low. The oldest unread word is always shown on `rd_data_o` while `rd_empty_o` is low, and it is consumed when `rd_ready_i` is high.

A 2-bit mode code tells the queue how its two clocks relate, and so how many register stages each Gray-coded pointer passes through on its way to the opposite domain. Code 2'b11 (same clock) uses no stage: the other side's pointer is used combinationally. Codes 2'b10 and 2'b01 (phase-aligned clocks at a 1:2 or 2:1 ratio) use one stage. Code 2'b00 (unrelated clocks) uses two stages. The stage count is symmetric, so it does not matter which side the faster clock sits on. The same block serves the command queue, the write-data queue and the read-data queue, each with its own depth.

Each domain has its own active-low asynchronous reset. The mode is captured while that domain's reset is low and is held once the reset is released.

Top module: `xport_fifo`

## Requirements
- R1: With mode 2'b11 and one clock driving both sides, `rd_empty_o` falls in the same cycle as the write edge, and `rd_data_o` shows the written word.
- R2: With mode 2'b10 or 2'b01 and one clock driving both sides, `rd_empty_o` falls one read-clock edge after the write edge.
- R3: With mode 2'b00 and one clock driving both sides, `rd_empty_o` falls two read-clock edges after the write edge.
- R4: After DEPTH writes with no reads, `wr_full_o` is high. Further writes are dropped, and reads then return exactly the first DEPTH words, after which `rd_empty_o` is high.
- R5: A read request while `rd_empty_o` is high has no effect. A word written afterwards is the next word read, and the queue is empty after that read.
- R6: In every mode with its matching clock ratio, and under throttled writes and reads, words leave in the order they were written. `rd_data_o` shows the oldest unread word whenever `rd_empty_o` is low. Each pointer moves by at most one Gray-code step per edge.
- R7: `rd_empty_o` never falls while there is no unread word, and writes are never accepted while `wr_full_o` is high.
- R8: The mode code is captured only while the domain resets are low. Changing `mode_i` after release does not change the crossing latency.
- R9: Asserting both resets clears any content: afterwards `rd_empty_o` is 1 and `wr_full_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 2 | Clock relation code: 11 same clock, 10/01 phase-aligned 1:2 or 2:1, 00 unrelated |
| wr_clk_i | input | 1 | Write-side clock |
| wr_rst_ni | input | 1 | Write-side asynchronous reset, active low |
| wr_valid_i | input | 1 | Push request |
| wr_data_i | input | DATA_W | Word to push |
| wr_full_o | output | 1 | No free slot; pushes are dropped |
| rd_clk_i | input | 1 | Read-side clock |
| rd_rst_ni | input | 1 | Read-side asynchronous reset, active low |
| rd_ready_i | input | 1 | Pop request |
| rd_data_o | output | DATA_W | Oldest unread word (valid while not empty) |
| rd_empty_o | output | 1 | No unread word; pops are ignored |

## Verification
A wrong stage count for a mode shows up directly at `rd_empty_o`. The flag falls zero, one or two read edges after a write, so a latency that is wrong by a single register is seen within three cycles of the first write. A corrupted pointer or a full/empty compare that lets a write or read through shows up as a reordered, duplicated or missing word on `rd_data_o` at the very next pop, or as the empty flag falling with nothing written. Throttled traffic in all four modes and the directed fill and drain cases push the pointers through wrap-around, where a bad wrap bit is exposed within one pass of DEPTH words.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  typedef enum logic [1:0] {
    XM_UNRELATED = 2'b00,
    XM_PORT_FAST = 2'b01,
    XM_PORT_SLOW = 2'b10,
    XM_SAME_CLK  = 2'b11
  } xmode_e;

  localparam int unsigned MAX_STAGES = 2;

  function automatic logic [1:0] stages_for(xmode_e m);
    case (m)
      XM_SAME_CLK:  return 2'd0;
      XM_UNRELATED: return 2'd2;
      default:      return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/xfifo_mode_latch.sv
module xfifo_mode_latch
  import xfifo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  output logic [1:0] stages_o
);
  xmode_e mode_q;

  // captured only while the local domain is held in reset
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= xmode_e'(mode_i);
  end

  assign stages_o = stages_for(mode_q);

  p_mode_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(mode_q))
    else $error("mode changed outside reset");

endmodule

// File: rtl/xfifo_ptr_sync.sv
module xfifo_ptr_sync #(
  parameter int unsigned PW     = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    stages_i,
  input  logic [PW-1:0] ptr_i,
  output logic [PW-1:0] ptr_o
);
  logic [STAGES-1:0][PW-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= ptr_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  // zero stages: combinational bypass, valid only with a shared clock
  always_comb begin
    ptr_o = ptr_i;
    for (int s = 0; s < STAGES; s++) begin
      if (int'(stages_i) == s + 1) ptr_o = chain_q[s];
    end
  end

endmodule

// File: rtl/xfifo_wr_ctrl.sv
module xfifo_wr_ctrl #(
  parameter int unsigned AW = 3,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [PW-1:0] rd_gray_i,
  output logic          full_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] gray_o
);
  localparam logic [PW-1:0] FULL_XOR = PW'(3) << (AW - 1);

  logic [PW-1:0] bin_q, gray_q, bin_d;
  logic          push;

  assign push  = valid_i & ~full_o;
  assign bin_d = bin_q + PW'(push);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= bin_d ^ (bin_d >> 1);
    end
  end

  // full: top two Gray bits inverted, rest equal
  assign full_o  = (gray_q ^ rd_gray_i) == FULL_XOR;
  assign we_o    = push;
  assign waddr_o = bin_q[AW-1:0];
  assign gray_o  = gray_q;

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && full_o) |=> $stable(gray_q))
    else $error("write pointer moved while full");

  p_wr_gray_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gray_q ^ $past(gray_q)))
    else $error("write pointer jumped more than one Gray step");

endmodule

// File: rtl/xfifo_rd_ctrl.sv
module xfifo_rd_ctrl #(
  parameter int unsigned AW = 3,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ready_i,
  input  logic [PW-1:0] wr_gray_i,
  output logic          empty_o,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] gray_o
);
  logic [PW-1:0] bin_q, gray_q, bin_d;
  logic          pop;

  assign pop   = ready_i & ~empty_o;
  assign bin_d = bin_q + PW'(pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= bin_d ^ (bin_d >> 1);
    end
  end

  assign empty_o = (gray_q == wr_gray_i);
  assign raddr_o = bin_q[AW-1:0];
  assign gray_o  = gray_q;

  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && empty_o) |=> $stable(gray_q))
    else $error("read pointer moved while empty");

  p_rd_gray_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gray_q ^ $past(gray_q)))
    else $error("read pointer jumped more than one Gray step");

endmodule

// File: rtl/xfifo_store.sv
module xfifo_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // first-word fall-through read
  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/xport_fifo.sv
module xport_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8
) (
  input  logic [1:0]        mode_i,
  input  logic              wr_clk_i,
  input  logic              wr_rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_full_o,
  input  logic              rd_clk_i,
  input  logic              rd_rst_ni,
  input  logic              rd_ready_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_empty_o
);
  import xfifo_pkg::*;

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [1:0]    wr_stages, rd_stages;
  logic [PW-1:0] wr_gray, rd_gray, wr_gray_at_rd, rd_gray_at_wr;
  logic [AW-1:0] waddr, raddr;
  logic          we;

  // write domain
  xfifo_mode_latch u_wr_mode (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .mode_i(mode_i), .stages_o(wr_stages)
  );

  xfifo_ptr_sync #(.PW(PW), .STAGES(MAX_STAGES)) u_rd2wr (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .stages_i(wr_stages),
    .ptr_i(rd_gray), .ptr_o(rd_gray_at_wr)
  );

  xfifo_wr_ctrl #(.AW(AW)) u_wr (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .valid_i(wr_valid_i),
    .rd_gray_i(rd_gray_at_wr), .full_o(wr_full_o), .we_o(we),
    .waddr_o(waddr), .gray_o(wr_gray)
  );

  // read domain
  xfifo_mode_latch u_rd_mode (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .mode_i(mode_i), .stages_o(rd_stages)
  );

  xfifo_ptr_sync #(.PW(PW), .STAGES(MAX_STAGES)) u_wr2rd (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .stages_i(rd_stages),
    .ptr_i(wr_gray), .ptr_o(wr_gray_at_rd)
  );

  xfifo_rd_ctrl #(.AW(AW)) u_rd (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .ready_i(rd_ready_i),
    .wr_gray_i(wr_gray_at_rd), .empty_o(rd_empty_o),
    .raddr_o(raddr), .gray_o(rd_gray)
  );

  xfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .wclk_i(wr_clk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wr_data_i),
    .raddr_i(raddr), .rdata_o(rd_data_o)
  );

endmodule

// File: tb/xport_fifo_tb_top.sv
`timescale 1ns/100ps
module xport_fifo_tb_top;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned DEPTH  = 8;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] wsel;   // 0 same, 1 half, 2 double, 3 unrelated
    logic [3:0] wthr;
    logic [3:0] rthr;
    logic [7:0] nwords;
  } vec_t;

  localparam vec_t VEC [0:4] = '{
    '{2'b11, 2'd0, 4'd0, 4'd9, 8'd40},
    '{2'b10, 2'd1, 4'd0, 4'd0, 8'd40},
    '{2'b01, 2'd2, 4'd3, 4'd0, 8'd60},
    '{2'b00, 2'd3, 4'd5, 4'd5, 8'd60},
    '{2'b00, 2'd3, 4'd0, 4'd12, 8'd50}
  };

  int total = 0;
  int bad   = 0;

  logic clk_core = 0, clk_half = 0, clk_dbl = 1, clk_unrel = 0;
  logic [1:0] wsel = 2'd0;
  logic wr_clk, rd_clk;

  initial forever #4 clk_core = ~clk_core;
  initial begin #4; forever begin clk_half = ~clk_half; #8; end end
  initial forever #2 clk_dbl = ~clk_dbl;
  initial forever #5.5 clk_unrel = ~clk_unrel;

  assign rd_clk = clk_core;
  assign wr_clk = (wsel == 2'd1) ? clk_half :
                  (wsel == 2'd2) ? clk_dbl  :
                  (wsel == 2'd3) ? clk_unrel : clk_core;

  logic [1:0]        mode;
  logic              wr_rst_n, rd_rst_n, wr_valid, rd_ready;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              wr_full, rd_empty;

  xport_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .mode_i(mode), .wr_clk_i(wr_clk), .wr_rst_ni(wr_rst_n),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_full_o(wr_full),
    .rd_clk_i(rd_clk), .rd_rst_ni(rd_rst_n), .rd_ready_i(rd_ready),
    .rd_data_o(rd_data), .rd_empty_o(rd_empty)
  );

  logic [DATA_W-1:0] sb [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  task automatic do_reset(input logic [1:0] m, input logic [1:0] ws);
    wr_rst_n = 0; rd_rst_n = 0; wr_valid = 0; rd_ready = 0;
    mode = m; wsel = ws;
    repeat (10) @(negedge clk_core);
    wr_rst_n = 1; rd_rst_n = 1;
    repeat (3) @(negedge clk_core);
  endtask

  task automatic writer(input int n, input logic [3:0] thr, input logic [DATA_W-1:0] base);
    logic [15:0] lf = 16'hACE1;
    int sent = 0;
    while (sent < n) begin
      @(negedge wr_clk);
      lf = step(lf);
      if (wr_full || lf[3:0] < thr) begin
        wr_valid = 0;
      end else begin
        wr_valid = 1;
        wr_data  = base + DATA_W'(sent);
        sb.push_back(wr_data);
        sent++;
      end
    end
    @(negedge wr_clk);
    wr_valid = 0;
  endtask

  task automatic reader(input int n, input logic [3:0] thr);
    logic [15:0] lf = 16'h1D2C;
    int got = 0;
    while (got < n) begin
      @(negedge rd_clk);
      rd_ready = 0;
      lf = step(lf);
      if (!rd_empty) begin
        if (sb.size() == 0) begin
          chk(0, "R7 empty fell with nothing written", 64'(rd_empty), 64'd1);
          got = n;
        end else if (lf[3:0] >= thr) begin
          chk(rd_data == sb[0], "R6 order", 64'(rd_data), 64'(sb[0]));
          void'(sb.pop_front());
          rd_ready = 1;
          got++;
        end
      end
    end
    @(negedge rd_clk);
    rd_ready = 0;
  endtask

  // write one word with a shared clock; empty must fall after S read edges
  task automatic latency(input logic [1:0] m_rst, input logic [1:0] m_run,
                         input int s, input string req);
    do_reset(m_rst, 2'd0);
    mode = m_run;
    @(negedge clk_core);
    wr_valid = 1; wr_data = 32'hC0DE_0000 + DATA_W'(s);
    @(negedge clk_core);
    wr_valid = 0;
    for (int k = 0; k < 3; k++) begin
      chk(rd_empty == (s > k), req, 64'(rd_empty), 64'(s > k));
      if (k > 0) @(negedge clk_core);
      if (k == 0) @(negedge clk_core);
    end
    chk(rd_data == 32'hC0DE_0000 + DATA_W'(s), req, 64'(rd_data),
        64'(32'hC0DE_0000 + DATA_W'(s)));
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wr_data = '0;

    // table-driven traffic in all four modes with matching ratios
    for (int i = 0; i < 5; i++) begin
      do_reset(VEC[i].mode, VEC[i].wsel);
      chk(rd_empty == 1'b1, "R9 empty after reset", 64'(rd_empty), 64'd1);
      chk(wr_full == 1'b0, "R9 not full after reset", 64'(wr_full), 64'd0);
      sb.delete();
      fork
        writer(int'(VEC[i].nwords), VEC[i].wthr, DATA_W'(i) << 24);
        reader(int'(VEC[i].nwords), VEC[i].rthr);
      join
      repeat (4) @(negedge rd_clk);
      chk(sb.size() == 0, "R6 all words read", 64'(sb.size()), 64'd0);
      chk(rd_empty == 1'b1, "R7 empty after drain", 64'(rd_empty), 64'd1);
    end

    // crossing latency per mode, shared clock
    latency(2'b11, 2'b11, 0, "R1 same-clock latency");
    latency(2'b10, 2'b10, 1, "R2 one-stage latency 10");
    latency(2'b01, 2'b01, 1, "R2 one-stage latency 01");
    latency(2'b00, 2'b00, 2, "R3 two-stage latency");
    // mode changed after release must not matter
    latency(2'b00, 2'b11, 2, "R8 mode held from reset");

    // R4: fill, overrun, drain
    do_reset(2'b11, 2'd0);
    for (int j = 0; j < DEPTH; j++) begin
      @(negedge clk_core);
      wr_valid = 1; wr_data = 32'hF000 + DATA_W'(j);
    end
    @(negedge clk_core);
    wr_valid = 0;
    chk(wr_full == 1'b1, "R4 full after DEPTH writes", 64'(wr_full), 64'd1);
    wr_valid = 1; wr_data = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk_core);
    wr_valid = 0;
    chk(wr_full == 1'b1, "R4 still full after dropped writes", 64'(wr_full), 64'd1);
    for (int j = 0; j < DEPTH; j++) begin
      chk(rd_data == 32'hF000 + DATA_W'(j), "R4 drain order", 64'(rd_data),
          64'(32'hF000 + DATA_W'(j)));
      rd_ready = 1;
      @(negedge clk_core);
    end
    rd_ready = 0;
    chk(rd_empty == 1'b1, "R4 empty after DEPTH reads", 64'(rd_empty), 64'd1);

    // R5: reads while empty are ignored
    do_reset(2'b11, 2'd0);
    rd_ready = 1;
    repeat (5) @(negedge clk_core);
    rd_ready = 0;
    chk(rd_empty == 1'b1, "R5 empty after idle reads", 64'(rd_empty), 64'd1);
    wr_valid = 1; wr_data = 32'h5A5A_0001;
    @(negedge clk_core);
    wr_valid = 0;
    chk(rd_empty == 1'b0, "R5 word visible", 64'(rd_empty), 64'd0);
    chk(rd_data == 32'h5A5A_0001, "R5 word intact", 64'(rd_data), 64'h5A5A_0001);
    rd_ready = 1;
    @(negedge clk_core);
    rd_ready = 0;
    chk(rd_empty == 1'b1, "R5 empty after single read", 64'(rd_empty), 64'd1);

    // R9: reset with content clears it
    for (int j = 0; j < 3; j++) begin
      wr_valid = 1; wr_data = DATA_W'(j);
      @(negedge clk_core);
    end
    wr_valid = 0;
    chk(rd_empty == 1'b0, "R9 content before reset", 64'(rd_empty), 64'd0);
    do_reset(2'b11, 2'd0);
    chk(rd_empty == 1'b1, "R9 empty after reset with content", 64'(rd_empty), 64'd1);
    chk(wr_full == 1'b0, "R9 not full after reset with content", 64'(wr_full), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule